// File: doc/BRIEF.md
# Sixty-Four-Bit Barrel Shifter with Word Variants

This block is a purely combinational shift unit for a 64-bit integer datapath. It performs a logical left shift, a logical right shift or an arithmetic right shift on a full-width operand. The same three operations are also available in a 32-bit word form. A word shift works only on the low half of the operand and returns its 32-bit result sign-extended to the full width.

The shift distance comes from a raw amount field. That field is either the low bits of a register operand or the shift-amount part of an instruction immediate, and a select input says which. Full-width shifts take six bits of distance and word shifts take five. An immediate word shift whose sixth amount bit is set is an encoding the architecture reserves, and the block raises a flag for it. The surrounding pipeline decides how to react to that flag. The block computes a result in every case, so the output never depends on whether the flag is set.

The datapath is a logarithmic right-shift network with a selectable fill bit. Left shifts reuse the same network by reversing the bit order on entry and on exit, so there is a single set of shift stages.

Top module: `shf_unit`

## Requirements
- R1: A full-width shift (`word_sel`=0) uses `amt_src[5:0]` as its distance. The bits of `amt_src` above bit 5 have no effect on `result`.
- R2: A word shift (`word_sel`=1) uses `amt_src[4:0]` as its distance. In register mode (`imm_sel`=0), `amt_src[5]` and all higher bits have no effect on `result` or on `rsv_enc`.
- R3: `dir_right`=0 selects a left shift, which fills the vacated low bits with zeros. `dir_right`=1 with `arith_sel`=0 fills the vacated high bits with zeros. `dir_right`=1 with `arith_sel`=1 fills the vacated high bits of a full-width shift with `op_a[63]`.
- R4: A word shift depends only on `op_a[31:0]`. `result[63:32]` always equals copies of `result[31]`.
- R5: A word arithmetic right shift fills from `op_a[31]`. `op_a[63]` plays no part in it.
- R6: `arith_sel` chooses the right-shift kind: 0 for logical, 1 for arithmetic. `arith_sel` has no effect on a left shift.
- R7: `rsv_enc` is 1 exactly when `word_sel`=1, `imm_sel`=1 and `amt_src[5]`=1. In that case `result` is still the word shift by `amt_src[4:0]`.
- R8: A word logical right shift by zero of an operand with bit 31 set returns the low word sign-extended, so the upper 32 bits are all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 64 | Operand to be shifted |
| amt_src | input | 12 | Raw amount field: low bits of a register, or an immediate field |
| dir_right | input | 1 | 0 = left shift, 1 = right shift |
| arith_sel | input | 1 | For right shifts: 0 = logical, 1 = arithmetic |
| word_sel | input | 1 | 0 = full 64-bit shift, 1 = 32-bit word shift |
| imm_sel | input | 1 | 0 = amount from a register, 1 = amount from an immediate |
| result | output | 64 | Shifted value, sign-extended from bit 31 for word shifts |
| rsv_enc | output | 1 | Reserved immediate word-shift encoding detected |

## Verification
The bench builds the block with its defaults: a 64-bit data width, a 32-bit word and a 12-bit amount field. With these values, every one of the 64 full-width distances and every one of the 32 word distances can be swept exhaustively for each of the three shift kinds. The 12-bit field also leaves six spare bits above the distance, and the bench sets them at random to show that they are ignored. Directed vectors cover the bit-31 fill and sign-extension corners. Random operands, compared against a reference built from the language's own shift operators, cover the rest.

// File: rtl/shf_pkg.sv
package shf_pkg;

  // Shift direction as seen on the dir_right input
  typedef enum logic {
    SHF_LEFT  = 1'b0,
    SHF_RIGHT = 1'b1
  } shf_dir_e;

  // Right-shift kind as seen on the arith_sel input
  typedef enum logic {
    SHF_LOGIC = 1'b0,
    SHF_ARITH = 1'b1
  } shf_kind_e;

  // Number of bits needed to encode a distance below a given width
  function automatic int unsigned dist_bits(input int unsigned width);
    return $clog2(width);
  endfunction

  // Fill bit for a right shift: sign source only for arithmetic right shifts
  function automatic logic pick_fill(input shf_dir_e dir, input shf_kind_e kind,
                                     input logic sign_src);
    return (dir == SHF_RIGHT) && (kind == SHF_ARITH) && sign_src;
  endfunction

endpackage

// File: rtl/shf_amt_dec.sv
module shf_amt_dec #(
  parameter int unsigned AMT_W = 12,
  parameter int unsigned SHW   = 6,
  parameter int unsigned WSHW  = 5
) (
  input  logic [AMT_W-1:0] amt_src,
  input  logic             word_sel,
  input  logic             imm_sel,
  output logic [SHW-1:0]   amt_eff,
  output logic             rsv_enc
);

  localparam int unsigned PAD_W = SHW - WSHW;

  logic [SHW-1:0] full_amt;
  logic [SHW-1:0] word_amt;
  logic           unused_hi;

  assign full_amt  = amt_src[SHW-1:0];
  assign word_amt  = {{PAD_W{1'b0}}, amt_src[WSHW-1:0]};
  assign unused_hi = ^amt_src[AMT_W-1:SHW];

  always_comb begin
    amt_eff = word_sel ? word_amt : full_amt;
    rsv_enc = word_sel & imm_sel & amt_src[WSHW];
  end

endmodule

// File: rtl/shf_operand_prep.sv
module shf_operand_prep #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned WLEN = 32
) (
  input  logic [XLEN-1:0] op_a,
  input  logic            dir_right,
  input  logic            arith_sel,
  input  logic            word_sel,
  output logic [XLEN-1:0] core_in,
  output logic            core_fill
);
  import shf_pkg::*;

  localparam int unsigned HI_W = XLEN - WLEN;

  logic [XLEN-1:0] framed;
  logic [XLEN-1:0] flipped;
  logic            sign_src;
  logic            fill_bit;

  assign sign_src = word_sel ? op_a[WLEN-1] : op_a[XLEN-1];
  assign fill_bit = pick_fill(shf_dir_e'(dir_right), shf_kind_e'(arith_sel), sign_src);

  // Word operands are framed with the fill bit above the low word so that a
  // right shift pulls the correct bits into the low half.
  always_comb begin
    if (word_sel) framed = {{HI_W{fill_bit}}, op_a[WLEN-1:0]};
    else          framed = op_a;
  end

  // Bit reversal turns a left shift into a right shift on the same network
  for (genvar i = 0; i < XLEN; i++) begin : g_rev
    assign flipped[i] = framed[XLEN-1-i];
  end

  assign core_in   = dir_right ? framed : flipped;
  assign core_fill = fill_bit;

endmodule

// File: rtl/shf_barrel_core.sv
module shf_barrel_core #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned SHW  = 6
) (
  input  logic [XLEN-1:0] din,
  input  logic [SHW-1:0]  amt,
  input  logic            fill,
  output logic [XLEN-1:0] dout
);

  logic [XLEN-1:0] stage [0:SHW];

  assign stage[0] = din;

  // One stage per distance bit, stage i moves by 2**i positions
  for (genvar i = 0; i < SHW; i++) begin : g_stage
    localparam int unsigned STEP = 1 << i;
    logic [XLEN-1:0] moved;
    assign moved        = {{STEP{fill}}, stage[i][XLEN-1:STEP]};
    assign stage[i+1]   = amt[i] ? moved : stage[i];
  end

  assign dout = stage[SHW];

endmodule

// File: rtl/shf_result_fmt.sv
module shf_result_fmt #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned WLEN = 32
) (
  input  logic [XLEN-1:0] core_out,
  input  logic            dir_right,
  input  logic            word_sel,
  output logic [XLEN-1:0] result
);

  localparam int unsigned HI_W = XLEN - WLEN;

  logic [XLEN-1:0] unflipped;
  logic [XLEN-1:0] oriented;

  for (genvar i = 0; i < XLEN; i++) begin : g_unrev
    assign unflipped[i] = core_out[XLEN-1-i];
  end

  assign oriented = dir_right ? core_out : unflipped;

  always_comb begin
    if (word_sel) result = {{HI_W{oriented[WLEN-1]}}, oriented[WLEN-1:0]};
    else          result = oriented;
  end

endmodule

// File: rtl/shf_unit.sv
module shf_unit #(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned WLEN  = 32,
  parameter int unsigned AMT_W = 12
) (
  input  logic [XLEN-1:0]  op_a,
  input  logic [AMT_W-1:0] amt_src,
  input  logic             dir_right,
  input  logic             arith_sel,
  input  logic             word_sel,
  input  logic             imm_sel,
  output logic [XLEN-1:0]  result,
  output logic             rsv_enc
);

  localparam int unsigned SHW  = shf_pkg::dist_bits(XLEN);
  localparam int unsigned WSHW = shf_pkg::dist_bits(WLEN);

  // Named internal events, visible to the bound checker
  logic [SHW-1:0]  amt_eff;
  logic [XLEN-1:0] core_in;
  logic            core_fill;
  logic [XLEN-1:0] core_out;

  shf_amt_dec #(.AMT_W(AMT_W), .SHW(SHW), .WSHW(WSHW)) u_dec (
    .amt_src  (amt_src),
    .word_sel (word_sel),
    .imm_sel  (imm_sel),
    .amt_eff  (amt_eff),
    .rsv_enc  (rsv_enc)
  );

  shf_operand_prep #(.XLEN(XLEN), .WLEN(WLEN)) u_prep (
    .op_a      (op_a),
    .dir_right (dir_right),
    .arith_sel (arith_sel),
    .word_sel  (word_sel),
    .core_in   (core_in),
    .core_fill (core_fill)
  );

  shf_barrel_core #(.XLEN(XLEN), .SHW(SHW)) u_core (
    .din  (core_in),
    .amt  (amt_eff),
    .fill (core_fill),
    .dout (core_out)
  );

  shf_result_fmt #(.XLEN(XLEN), .WLEN(WLEN)) u_fmt (
    .core_out  (core_out),
    .dir_right (dir_right),
    .word_sel  (word_sel),
    .result    (result)
  );

endmodule

// File: rtl/shf_unit_chk.sv
module shf_unit_chk #(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned WLEN  = 32,
  parameter int unsigned AMT_W = 12,
  parameter int unsigned SHW   = 6
) (
  input logic [XLEN-1:0]  op_a,
  input logic [AMT_W-1:0] amt_src,
  input logic             dir_right,
  input logic             arith_sel,
  input logic             word_sel,
  input logic             imm_sel,
  input logic [XLEN-1:0]  result,
  input logic             rsv_enc,
  input logic [SHW-1:0]   amt_eff
);

  logic [XLEN-1:0] low_mask;
  logic            unused_chk;

  assign low_mask   = ({{(XLEN-1){1'b0}}, 1'b1} << amt_eff) - 1'b1;
  assign unused_chk = ^amt_src[AMT_W-1:SHW];

  always_comb begin
    if (rsv_enc) begin
      AST_RSV_ONLY_WORD_IMM: assert (word_sel && imm_sel && amt_src[SHW-1]); // R7
    end
    if (word_sel) begin
      AST_WORD_SIGN_EXT: assert (result[XLEN-1:WLEN] == {(XLEN-WLEN){result[WLEN-1]}}); // R4
      AST_WORD_DIST_LIMIT: assert (amt_eff[SHW-1] == 1'b0); // R2
    end
    if (!word_sel && amt_eff == '0) begin
      AST_FULL_ZERO_PASS: assert (result == op_a); // R1
    end
    if (!word_sel && !dir_right) begin
      AST_LEFT_ZERO_FILL: assert ((result & low_mask) == '0); // R3
    end
    if (!word_sel && dir_right && !arith_sel && amt_eff != '0) begin
      AST_LRIGHT_ZERO_TOP: assert (result[XLEN-1] == 1'b0); // R3
    end
    if (!word_sel && dir_right && arith_sel) begin
      AST_ARIGHT_KEEP_SIGN: assert (result[XLEN-1] == op_a[XLEN-1]); // R6
    end
    if (word_sel && dir_right && arith_sel) begin
      AST_WORD_FILL_BIT31: assert (result[XLEN-1] == op_a[WLEN-1]); // R5
    end
  end

endmodule

bind shf_unit shf_unit_chk #(.XLEN(XLEN), .WLEN(WLEN), .AMT_W(AMT_W), .SHW(SHW)) u_chk (
  .op_a      (op_a),
  .amt_src   (amt_src),
  .dir_right (dir_right),
  .arith_sel (arith_sel),
  .word_sel  (word_sel),
  .imm_sel   (imm_sel),
  .result    (result),
  .rsv_enc   (rsv_enc),
  .amt_eff   (amt_eff)
);

// File: tb/shf_unit_tb.sv
`timescale 1ns/1ps
module shf_unit_tb;

  localparam int unsigned XLEN  = 64;
  localparam int unsigned AMT_W = 12;
  localparam int unsigned NVEC  = 12;
  localparam int unsigned WDOG  = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [XLEN-1:0]  op_a;
  logic [AMT_W-1:0] amt_src;
  logic dir_right, arith_sel, word_sel, imm_sel;
  logic [XLEN-1:0]  result;
  logic             rsv_enc;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;
  logic done = 1'b0;

  shf_unit u_dut (
    .op_a(op_a), .amt_src(amt_src), .dir_right(dir_right), .arith_sel(arith_sel),
    .word_sel(word_sel), .imm_sel(imm_sel), .result(result), .rsv_enc(rsv_enc)
  );

  // Fields: op, amount, dir, arith, word, imm, expected result, expected flag
  typedef struct packed {
    logic [63:0] op;
    logic [11:0] amt;
    logic        dr;
    logic        ar;
    logic        wd;
    logic        im;
    logic [63:0] exp;
    logic        rsv;
  } vec_t;

  localparam vec_t TBL [NVEC] = '{
    {64'h8000_0000_0000_0001, 12'h001, 1'b1, 1'b1, 1'b0, 1'b0, 64'hC000_0000_0000_0000, 1'b0}, // R3
    {64'h8000_0000_0000_0001, 12'h001, 1'b1, 1'b0, 1'b0, 1'b0, 64'h4000_0000_0000_0000, 1'b0}, // R3
    {64'h0000_0000_0000_0001, 12'h03F, 1'b0, 1'b0, 1'b0, 1'b0, 64'h8000_0000_0000_0000, 1'b0}, // R3
    {64'h0000_0000_0000_0001, 12'h041, 1'b0, 1'b0, 1'b0, 1'b0, 64'h0000_0000_0000_0002, 1'b0}, // R1
    {64'h0000_0000_8000_0000, 12'h000, 1'b1, 1'b0, 1'b1, 1'b0, 64'hFFFF_FFFF_8000_0000, 1'b0}, // R8
    {64'h0000_0000_8000_0000, 12'h004, 1'b1, 1'b1, 1'b1, 1'b0, 64'hFFFF_FFFF_F800_0000, 1'b0}, // R5
    {64'h8000_0000_0000_0000, 12'h004, 1'b1, 1'b1, 1'b1, 1'b0, 64'h0000_0000_0000_0000, 1'b0}, // R5
    {64'h0000_0000_4000_0000, 12'h001, 1'b0, 1'b0, 1'b1, 1'b0, 64'hFFFF_FFFF_8000_0000, 1'b0}, // R4
    {64'h0000_0000_0000_0001, 12'h021, 1'b0, 1'b0, 1'b1, 1'b0, 64'h0000_0000_0000_0002, 1'b0}, // R2
    {64'h0000_0000_0000_0001, 12'h021, 1'b0, 1'b0, 1'b1, 1'b1, 64'h0000_0000_0000_0002, 1'b1}, // R7
    {64'h0000_0000_0000_0001, 12'h004, 1'b0, 1'b1, 1'b0, 1'b0, 64'h0000_0000_0000_0010, 1'b0}, // R6
    {64'hFFFF_FFFF_8000_0000, 12'h004, 1'b1, 1'b0, 1'b1, 1'b0, 64'h0000_0000_0800_0000, 1'b0}  // R4
  };

  // Reference built from the language's shift operators
  function automatic logic [63:0] ref_shift(input logic [63:0] op, input logic [11:0] amt,
                                            input logic dr, input logic ar, input logic wd);
    logic [31:0] w;
    logic [63:0] r;
    if (wd) begin
      if (!dr)     w = op[31:0] << amt[4:0];
      else if (ar) w = $unsigned($signed(op[31:0]) >>> amt[4:0]);
      else         w = op[31:0] >> amt[4:0];
      r = {{32{w[31]}}, w};
    end else begin
      if (!dr)     r = op << amt[5:0];
      else if (ar) r = $unsigned($signed(op) >>> amt[5:0]);
      else         r = op >> amt[5:0];
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [63:0] op, input logic [11:0] amt, input logic dr,
                       input logic ar, input logic wd, input logic im);
    @(negedge clk);
    op_a = op; amt_src = amt; dir_right = dr; arith_sel = ar; word_sel = wd; imm_sel = im;
    #1;
  endtask

  task automatic run_ref(input string tag, input logic [63:0] op, input logic [11:0] amt,
                         input logic dr, input logic ar, input logic wd, input logic im);
    apply(op, amt, dr, ar, wd, im);
    check(tag, result, ref_shift(op, amt, dr, ar, wd));
    check({tag, " flag"}, {63'd0, rsv_enc}, {63'd0, wd & im & amt[5]});
  endtask

  initial begin
    op_a = '0; amt_src = '0; dir_right = 1'b0; arith_sel = 1'b0; word_sel = 1'b0; imm_sel = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    check("reset R1", result, 64'd0);
    check("reset R7", {63'd0, rsv_enc}, 64'd0);

    for (int i = 0; i < NVEC; i++) begin
      apply(TBL[i].op, TBL[i].amt, TBL[i].dr, TBL[i].ar, TBL[i].wd, TBL[i].im);
      check($sformatf("table %0d result R1-R8 set", i), result, TBL[i].exp);
      check($sformatf("table %0d flag R7", i), {63'd0, rsv_enc}, {63'd0, TBL[i].rsv});
    end

    // Full-width sweep, upper amount bits random: R1 R3 R6
    for (int k = 0; k < 64; k++) begin
      for (int m = 0; m < 3; m++) begin
        logic [63:0] op;
        logic [5:0]  hi;
        op = {$urandom, $urandom};
        hi = 6'($urandom);
        run_ref("full sweep R1 R3 R6", op, {hi, 6'(k)}, m != 0, m == 2, 1'b0, 1'($urandom));
      end
    end

    // Word sweep, upper operand and amount bits random: R2 R4 R5
    for (int k = 0; k < 32; k++) begin
      for (int m = 0; m < 3; m++) begin
        logic [63:0] op;
        logic [6:0]  hi;
        op = {$urandom, $urandom};
        hi = 7'($urandom);
        run_ref("word sweep R2 R4 R5", op, {hi, 5'(k)}, m != 0, m == 2, 1'b1, 1'b0);
      end
    end

    // Immediate word shifts with the reserved bit: R7
    for (int k = 0; k < 32; k++) begin
      run_ref("imm word R7", {$urandom, $urandom}, {6'd0, 1'b1, 5'(k)}, 1'b1, 1'b1, 1'b1, 1'b1);
    end

    // Word logical right by zero, bit 31 set: R8
    run_ref("srl0 R8", 64'h1234_5678_8765_4321, 12'h000, 1'b1, 1'b0, 1'b1, 1'b0);

    // Random everything
    for (int n = 0; n < 1500; n++) begin
      run_ref("random R1-R8 mix", {$urandom, $urandom}, 12'($urandom), 1'($urandom),
              1'($urandom), 1'($urandom), 1'($urandom));
    end

    done = 1'b1;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles >= WDOG && !done) begin
      n_chk  = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: got %0d cycles expected below %0d", cycles, WDOG);
      done = 1'b1;
    end
  end

  initial begin
    wait (done);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule